// File: doc/BRIEF.md
# Log-Domain Base/Detail Luminance Compressor

This stage squeezes a wide luminance stream into the narrow code range of a display path. Each accepted cycle brings a 14-bit luminance sample and its edge-preserving smoothed version (the base), already aligned in time by an upstream filter. The block takes both into a fixed-point log2 domain. There the detail layer is the difference between the two logs, which is the ratio of pixel to base in linear terms.

Only the base log is scaled by a programmable contrast gain. A signed offset is then added, and the detail is added back unscaled. Local texture therefore keeps its relative size while the large-scale contrast shrinks. The sum is turned back into a linear value by an exp2 table and a shift, and saturated to 10 bits.

The block is a fixed six-stage pipeline with no frame storage and accepts one pair per cycle. Colour handling and the smoothing filter sit outside it. The gain and offset are treated as static while pixels are in flight.

Top module: `drc_compressor`

## Requirements
- R1: An input value of 0, on either the pixel or the base, is replaced by 1 before its logarithm is taken.
- R2: For each input value v, the log value is 256*p + f, where p is the position of the leading one of v (0 to 13). The 13 bits below the leading one form a fraction. Its top 6 bits select entries T[i] and T[i+1] of a table with T[i] = round(256*log2(1 + i/64)) for i = 0..64, so that T[64] = 256. f = T[i] + floor((T[i+1]-T[i])*r/128), where r is the low 7 bits of the fraction. The detail term is log(pixel) - log(base), a signed value.
- R3: The compressed base is floor(log(base) * g / 128). Here g is the 8-bit unsigned gain, read as a fraction with 7 fraction bits, so 128 means 1.0.
- R4: The recombined value is s = compressed base + detail + o. Here o is the 13-bit two's-complement offset, in units of 1/256 of one octave.
- R5: Let e = floor(s/256) and let q be the low 8 bits of s. The top 6 bits of q are j and the low 2 bits are u. The mantissa is m = E[j] + floor((E[j+1]-E[j])*u/4), with E[j] = round(256*2^(j/64)) for j = 0..64. For 0 <= e <= 9 the output is min(floor(m*2^e/256), 1023).
- R6: When e >= 10 the output is 1023.
- R7: When e < 0 the output is 0.
- R8: out_valid equals in_valid delayed by exactly 6 clock cycles, with back-to-back pairs accepted every cycle. The results leave in input order.
- R9: While out_valid is low, out_pix keeps the value of the last valid result.
- R10: While rst_n is low, out_valid and out_pix are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Qualifies in_pix and in_base this cycle |
| in_pix | input | 14 | Wide-range luminance sample |
| in_base | input | 14 | Smoothed base value aligned with in_pix |
| cfg_gain | input | 8 | Base contrast gain, unsigned, 7 fraction bits |
| cfg_offset | input | 13 | Signed log-domain offset, 1/256 octave units |
| out_valid | output | 1 | Qualifies out_pix |
| out_pix | output | 10 | Compressed display luminance |

## Verification
The exp2 path can hit its two clamps, overflow to 1023 and underflow to 0, in neighbouring cycles of one burst. That can happen while the pipeline also accepts a new pair every cycle, so a clamp decision and the valid delay line work in the same cycle. Bursts are driven that alternate a full-scale pair with high gain and a pair pushed below one by a large negative offset, with no idle cycles between them. The offset stays fixed within a burst, so the tiny pairs are chosen to have a very small log value. Each output cycle is judged against a bench model of the whole log, scale, recombine and exp chain, and out_valid is checked against the bench's own record of in_valid from six cycles before.

// File: rtl/drc_pkg.sv
package drc_pkg;

  // log/exp fixed point: fraction bits of the log domain
  localparam int LOG_FW     = 8;
  // address bits of both lookup tables (64 entries plus end point)
  localparam int TAB_AW     = 6;
  // fraction bits of the contrast gain
  localparam int GAIN_FW    = 7;
  // fixed pipeline depth, input edge to output register
  localparam int PIPE_DEPTH = 6;

  // round(2^fw * log2(1 + i/n))
  function automatic int log_tab_val(input int i, input int fw, input int n);
    real x;
    x = 1.0 + real'(i) / real'(n);
    return $rtoi($floor(real'(1 << fw) * $ln(x) / $ln(2.0) + 0.5));
  endfunction

  // round(2^fw * 2^(j/n))
  function automatic int exp_tab_val(input int j, input int fw, input int n);
    return $rtoi($floor(real'(1 << fw) * $pow(2.0, real'(j) / real'(n)) + 0.5));
  endfunction

endpackage

// File: rtl/drc_valid_pipe.sv
module drc_valid_pipe #(
  parameter int DEPTH = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           din,
  output logic [DEPTH:1] taps
);

  logic [DEPTH:0] chain;

  assign chain[0] = din;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[DEPTH:1] <= '0;
    else        chain[DEPTH:1] <= chain[DEPTH-1:0];
  end

  assign taps = chain[DEPTH:1];

endmodule

// File: rtl/drc_log2.sv
module drc_log2 #(
  parameter  int IN_W = 14,
  parameter  int FW   = 8,
  parameter  int AW   = 6,
  localparam int PW   = $clog2(IN_W),
  localparam int OW   = PW + FW
) (
  input  logic [IN_W-1:0] val,
  output logic [OW-1:0]   log_o
);

  localparam int MW  = IN_W - 1;      // bits below the leading one
  localparam int RW  = MW - AW;       // interpolation remainder bits
  localparam int TN  = 1 << AW;
  localparam int PRW = FW + 1 + RW;

  logic [FW:0] tab [TN+1];

  for (genvar i = 0; i <= TN; i++) begin : g_tab
    assign tab[i] = (FW+1)'(drc_pkg::log_tab_val(i, FW, TN));
  end

  logic [PW-1:0]  pos;
  logic [MW-1:0]  norm;
  logic [AW:0]    idx_lo, idx_hi;
  logic [RW-1:0]  rem;
  logic [FW:0]    lo, hi, step, fsum;
  logic [PRW-1:0] prod;

  always_comb begin
    pos = '0;
    for (int b = 1; b < IN_W; b++) begin
      if (val[b]) pos = PW'(b);
    end
    norm   = MW'(val << (PW'(MW) - pos));
    idx_lo = {1'b0, norm[MW-1 -: AW]};
    idx_hi = idx_lo + (AW+1)'(1);
    rem    = norm[RW-1:0];
    lo     = tab[idx_lo];
    hi     = tab[idx_hi];
    step   = hi - lo;
    prod   = PRW'(step) * PRW'(rem);
    fsum   = lo + (FW+1)'(prod >> RW);
    log_o  = {pos, FW'(fsum)};
  end

endmodule

// File: rtl/drc_exp2.sv
module drc_exp2 #(
  parameter  int FW = 8,
  parameter  int AW = 6,
  localparam int MANT_W = FW + 2
) (
  input  logic [FW-1:0]     frac,
  output logic [MANT_W-1:0] mant
);

  localparam int RW  = FW - AW;
  localparam int TN  = 1 << AW;
  localparam int PRW = MANT_W + RW;

  logic [MANT_W-1:0] tab [TN+1];

  for (genvar j = 0; j <= TN; j++) begin : g_tab
    assign tab[j] = MANT_W'(drc_pkg::exp_tab_val(j, FW, TN));
  end

  logic [AW:0]       idx_lo, idx_hi;
  logic [RW-1:0]     rem;
  logic [MANT_W-1:0] lo, hi, step;
  logic [PRW-1:0]    prod;

  always_comb begin
    idx_lo = {1'b0, frac[FW-1 -: AW]};
    idx_hi = idx_lo + (AW+1)'(1);
    rem    = frac[RW-1:0];
    lo     = tab[idx_lo];
    hi     = tab[idx_hi];
    step   = hi - lo;
    prod   = PRW'(step) * PRW'(rem);
    mant   = lo + MANT_W'(prod >> RW);
  end

endmodule

// File: rtl/drc_compressor.sv
module drc_compressor
  import drc_pkg::*;
#(
  parameter int PIX_W  = 14,
  parameter int OUT_W  = 10,
  parameter int GAIN_W = 8,
  parameter int OFS_W  = 13
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [PIX_W-1:0]        in_pix,
  input  logic [PIX_W-1:0]        in_base,
  input  logic [GAIN_W-1:0]       cfg_gain,
  input  logic signed [OFS_W-1:0] cfg_offset,
  output logic                    out_valid,
  output logic [OUT_W-1:0]        out_pix
);

  localparam int POS_W  = $clog2(PIX_W);
  localparam int LOG_W  = POS_W + LOG_FW;
  localparam int CB_W   = LOG_W + GAIN_W - GAIN_FW;
  localparam int DET_W  = LOG_W + 1;
  localparam int SUM_W  = CB_W + 3;
  localparam int EXP_W  = SUM_W - LOG_FW;
  localparam int MANT_W = LOG_FW + 2;
  localparam int SH_W   = $clog2(OUT_W);
  localparam int WIDE_W = MANT_W + (1 << SH_W);
  localparam logic [OUT_W-1:0] OUT_MAX = '1;

  // ---------------- arithmetic helpers ----------------
  function automatic logic [PIX_W-1:0] lift_zero(input logic [PIX_W-1:0] v);
    return (v == '0) ? PIX_W'(1) : v;
  endfunction

  function automatic logic [CB_W-1:0] scale_base(input logic [LOG_W-1:0] lb,
                                                 input logic [GAIN_W-1:0] g);
    logic [LOG_W+GAIN_W-1:0] p;
    p = (LOG_W+GAIN_W)'(lb) * (LOG_W+GAIN_W)'(g);
    return p[LOG_W+GAIN_W-1:GAIN_FW];
  endfunction

  function automatic logic signed [SUM_W-1:0] recombine(
      input logic [CB_W-1:0]         cb,
      input logic signed [DET_W-1:0] det,
      input logic signed [OFS_W-1:0] ofs);
    logic signed [SUM_W-1:0] a, b, c;
    a = $signed({{(SUM_W-CB_W){1'b0}}, cb});
    b = $signed({{(SUM_W-DET_W){det[DET_W-1]}}, det});
    c = $signed({{(SUM_W-OFS_W){ofs[OFS_W-1]}}, ofs});
    return a + b + c;
  endfunction

  function automatic logic [OUT_W-1:0] shift_clamp(input logic [MANT_W-1:0] m,
                                                   input logic [SH_W-1:0] sh);
    logic [WIDE_W-1:0] w;
    w = WIDE_W'(m) << sh;
    w = w >> LOG_FW;
    return (w > WIDE_W'(OUT_MAX)) ? OUT_MAX : OUT_W'(w);
  endfunction

  // ---------------- valid delay line ----------------
  logic [PIPE_DEPTH:1] vld;

  drc_valid_pipe #(.DEPTH(PIPE_DEPTH)) u_vpipe (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (in_valid),
    .taps (vld)
  );

  // ---------------- stage 1: capture, zero lifted to one ----------------
  logic [PIX_W-1:0] px1, bs1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      px1 <= '0;
      bs1 <= '0;
    end else if (in_valid) begin
      px1 <= lift_zero(in_pix);
      bs1 <= lift_zero(in_base);
    end
  end

  // ---------------- stage 2: log2 of both ----------------
  logic [LOG_W-1:0] lp_c, lb_c, lp2, lb2;

  drc_log2 #(.IN_W(PIX_W), .FW(LOG_FW), .AW(TAB_AW)) u_log_pix (
    .val  (px1),
    .log_o(lp_c)
  );

  drc_log2 #(.IN_W(PIX_W), .FW(LOG_FW), .AW(TAB_AW)) u_log_base (
    .val  (bs1),
    .log_o(lb_c)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lp2 <= '0;
      lb2 <= '0;
    end else if (vld[1]) begin
      lp2 <= lp_c;
      lb2 <= lb_c;
    end
  end

  // ---------------- stage 3: detail and compressed base ----------------
  logic signed [DET_W-1:0] det3;
  logic [CB_W-1:0]         cb3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      det3 <= '0;
      cb3  <= '0;
    end else if (vld[2]) begin
      det3 <= $signed({1'b0, lp2}) - $signed({1'b0, lb2});
      cb3  <= scale_base(lb2, cfg_gain);
    end
  end

  // ---------------- stage 4: recombine with offset ----------------
  logic signed [SUM_W-1:0] sum4;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sum4 <= '0;
    else if (vld[3]) sum4 <= recombine(cb3, det3, cfg_offset);
  end

  // ---------------- stage 5: exp2 mantissa and exponent decode ----------------
  logic [MANT_W-1:0]       mant_c, mant5;
  logic signed [EXP_W-1:0] exp_c;
  logic                    sat_c, under_c;
  logic [SH_W-1:0]         sh5;
  logic                    sat5, under5;

  drc_exp2 #(.FW(LOG_FW), .AW(TAB_AW)) u_exp (
    .frac(sum4[LOG_FW-1:0]),
    .mant(mant_c)
  );

  assign exp_c   = $signed(sum4[SUM_W-1:LOG_FW]);
  assign under_c = exp_c[EXP_W-1];
  assign sat_c   = !under_c && (exp_c >= $signed(EXP_W'(OUT_W)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mant5  <= '0;
      sh5    <= '0;
      sat5   <= 1'b0;
      under5 <= 1'b0;
    end else if (vld[4]) begin
      mant5  <= mant_c;
      sh5    <= SH_W'(exp_c);
      sat5   <= sat_c;
      under5 <= under_c;
    end
  end

  // ---------------- stage 6: shift and saturate ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_pix <= '0;
    end else if (vld[5]) begin
      if (under5)    out_pix <= '0;
      else if (sat5) out_pix <= OUT_MAX;
      else           out_pix <= shift_clamp(mant5, sh5);
    end
  end

  assign out_valid = vld[PIPE_DEPTH];

  // ---------------- named events for the checker ----------------
  logic ev_flat_in, ev_sat, ev_under;

  assign ev_flat_in = vld[1] && (px1 == bs1);
  assign ev_sat     = vld[5] && sat5;
  assign ev_under   = vld[5] && under5;

endmodule

// File: rtl/drc_compressor_chk.sv
module drc_compressor_chk #(
  parameter int OUT_W = 10,
  parameter int DET_W = 13
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic                    out_valid,
  input logic [OUT_W-1:0]        out_pix,
  input logic                    ev_flat_in,
  input logic signed [DET_W-1:0] det3,
  input logic                    ev_sat,
  input logic                    ev_under
);

  logic [3:0] since_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 since_rst <= '0;
    else if (since_rst < 4'd6)  since_rst <= since_rst + 4'd1;
  end

  // R2: equal pixel and base give a zero detail two cycles later
  assert_flat_detail_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_flat_in |-> ##2 (det3 == '0));

  // R6: exponent overflow clamps the next output to full scale
  assert_sat_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sat |=> (out_valid && out_pix == '1));

  // R7: negative exponent yields zero
  assert_underflow_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_under |=> (out_valid && out_pix == '0));

  // R8: fixed six-cycle valid latency
  assert_valid_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 4'd6) |-> (out_valid == $past(in_valid, 6)));

  // R9: output holds between valid results
  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_pix));

  // R10: reset clears the output side
  assert_reset_clear_R10: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && out_pix == '0));

endmodule

bind drc_compressor drc_compressor_chk #(.OUT_W(OUT_W), .DET_W(DET_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .out_pix   (out_pix),
  .ev_flat_in(ev_flat_in),
  .det3      (det3),
  .ev_sat    (ev_sat),
  .ev_under  (ev_under)
);

// File: tb/drc_compressor_bench.sv
module drc_compressor_bench;

  localparam int PIX_W = 14;
  localparam int OUT_W = 10;
  localparam int GAIN_W = 8;
  localparam int OFS_W = 13;
  localparam int LAT = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [PIX_W-1:0] in_pix = '0;
  logic [PIX_W-1:0] in_base = '0;
  logic [GAIN_W-1:0] cfg_gain = 8'd128;
  logic signed [OFS_W-1:0] cfg_offset = '0;
  logic out_valid;
  logic [OUT_W-1:0] out_pix;

  always #5 clk = ~clk;

  drc_compressor u_drc_compressor (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pix(in_pix),
    .in_base(in_base), .cfg_gain(cfg_gain), .cfg_offset(cfg_offset),
    .out_valid(out_valid), .out_pix(out_pix)
  );

  int n_checks = 0;
  int n_fail = 0;
  int lt[65];
  int et[65];
  int exp_q[$];
  string tag_q[$];
  bit vh[8];
  int t = 0;
  int last_out = 0;
  int cur_gain = 128;
  int cur_ofs = 0;

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  // log table from R2, computed through base-10 logs
  function automatic void build_tables();
    for (int i = 0; i <= 64; i++) begin
      lt[i] = $rtoi($floor(256.0 * $log10(1.0 + i / 64.0) / $log10(2.0) + 0.5));
      et[i] = $rtoi($floor(256.0 * $exp($ln(2.0) * i / 64.0) + 0.5));
    end
  endfunction

  function automatic int blog(input int xin);
    int x, p, nrm, idx, r;
    x = (xin == 0) ? 1 : xin;
    p = 0;
    for (int b = 0; b < PIX_W; b++) if (((x >> b) & 1) == 1) p = b;
    nrm = (x << (13 - p)) & 8191;
    idx = nrm >> 7;
    r = nrm & 127;
    return p * 256 + lt[idx] + (((lt[idx+1] - lt[idx]) * r) >> 7);
  endfunction

  function automatic int ref_out(input int px, input int bs, input int k, input int o);
    int lp, lb, s, e, q, j, u, m, v;
    lp = blog(px);
    lb = blog(bs);
    s = ((lb * k) >> 7) + (lp - lb) + o;
    e = s >>> 8;
    q = s & 255;
    j = q >> 2;
    u = q & 3;
    m = et[j] + (((et[j+1] - et[j]) * u) >> 2);
    if (e < 0) return 0;
    if (e >= 10) return 1023;
    v = (m << e) >> 8;
    return (v > 1023) ? 1023 : v;
  endfunction

  task automatic step(input bit v, input int px, input int bs, input string tag);
    bit exp_ov;
    int e;
    string tg;
    @(negedge clk);
    exp_ov = (t >= LAT) ? vh[(t - LAT) % 8] : 1'b0;
    check(out_valid == exp_ov, "R8", int'(out_valid), int'(exp_ov));
    if (out_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R8", int'(out_pix), -1);
      end else begin
        e = exp_q.pop_front();
        tg = tag_q.pop_front();
        check(int'(out_pix) == e, tg, int'(out_pix), e);
      end
      last_out = int'(out_pix);
    end else begin
      check(int'(out_pix) == last_out, "R9", int'(out_pix), last_out);
    end
    in_valid = v;
    in_pix = PIX_W'(px);
    in_base = PIX_W'(bs);
    if (v) begin
      exp_q.push_back(ref_out(px, bs, cur_gain, cur_ofs));
      tag_q.push_back(tag);
    end
    vh[t % 8] = v;
    t++;
  endtask

  task automatic set_cfg(input int k, input int o);
    repeat (8) step(1'b0, 0, 0, "");
    cur_gain = k;
    cur_ofs = o;
    cfg_gain = GAIN_W'(k);
    cfg_offset = OFS_W'(o);
  endtask

  initial begin
    #(10 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks + 1);
    $finish;
  end

  initial begin
    int px, bs;
    build_tables();
    void'($urandom(32'd7341));
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0 && out_pix == '0, "R10", int'(out_pix), 0);
    rst_n = 1'b1;

    // R1: zeros behave as ones
    set_cfg(128, 0);
    step(1'b1, 0, 0, "R1");
    step(1'b1, 1, 1, "R1");
    step(1'b1, 0, 500, "R1");
    step(1'b1, 500, 0, "R1");
    // R3: unit gain returns roughly the pixel, half gain on flat pairs
    step(1'b1, 700, 300, "R3");
    step(1'b1, 1000, 1000, "R3");
    set_cfg(64, 0);
    step(1'b1, 1000, 1000, "R3");
    step(1'b1, 9000, 2000, "R3");
    // R4: positive offset of one octave
    set_cfg(128, 256);
    step(1'b1, 300, 300, "R4");
    // R5: pure offset on unity input, 2^8.5
    set_cfg(128, 8 * 256 + 128);
    step(1'b1, 1, 1, "R5");
    step(1'b1, 3, 1, "R5");
    // R6 / R7 back to back, fixed offset, alternating extremes
    set_cfg(255, -1800);
    for (int i = 0; i < 12; i++) begin
      if (i % 2 == 0) step(1'b1, 16383, 16383, "R6");
      else            step(1'b1, 1, 1, "R7");
    end
    set_cfg(128, 0);
    step(1'b1, 1023, 1023, "R5");
    step(1'b1, 1024, 1024, "R6");
    set_cfg(0, -4096);
    step(1'b1, 1, 1, "R7");
    // R8: long gapless burst
    set_cfg(100, 300);
    for (int i = 0; i < 20; i++) step(1'b1, 40 * i + 5, 37 * i + 9, "R8");
    // R2: random pairs with random gaps and settings
    for (int i = 0; i < 800; i++) begin
      if (i % 160 == 0) set_cfg(int'($urandom_range(0, 255)), int'($urandom_range(0, 8191)) - 4096);
      px = int'($urandom_range(0, 16383)) >> ($urandom % 10);
      bs = ($urandom % 3 == 0) ? px : int'($urandom_range(0, 16383)) >> ($urandom % 10);
      step(($urandom % 4) != 0, px, bs, "R2");
    end
    repeat (10) step(1'b0, 0, 0, "");
    check(exp_q.size() == 0, "R8", exp_q.size(), 0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule